// File: doc/BRIEF.md
# Memory Bandwidth Monitor with Port Filters

This block watches the request and grant strobes of a memory controller and counts them. Each grant carries a port number. Two counters see every request and every grant. Each of a set of channels, four by default, also has a grant counter behind its own two-level port filter. The first level is a mask of 32 major ports. The second level is a mask of device subports, which is reached through major-port bit 23.

Software programs the block through a word-addressed register file on a simple select/enable read/write bus. In the simplest mode the counters run freely and software reads them at any time. In timer mode, a cycle counter splits time into windows of a programmed number of clock cycles. At the end of each window the block does four things: it freezes the counts into the readable registers, clears the live counters, sets an interrupt flag and starts the next window. The interrupt output follows that flag. Software clears the flag by writing a one to it.

Top module: `bwmon_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While control bit 31 is set, the all-request counter (index 9) counts every cycle with `req_stb` high, and the all-grant counter (index 10) counts every cycle with `gnt_stb` high. The filters and the channel enables do not affect these two counters.
- R3: While control bit 31 is clear, no counter changes on strobes. Writing control to zero leaves the counter values unchanged.
- R4: A grant whose port p is below 32 adds one to channel c's counter (index 11+c) when bit 31 is set, control bit c (bits 3:0) is set and bit p of the channel's major mask (index 1+2c) is set.
- R5: A grant whose port p is 32 or above uses subport s = p-32. It adds one to channel c when bit 23 of the major mask is set and bit s of the subport mask (index 2+2c, 16 bits) is set. Subports of 16 and above never match.
- R6: When bits 31 and 20 are both set and the timer register (index 15) holds N > 0, a window ends every N cycles. The first window ends so that `irq` rises N clock edges after the edge that writes the control register. No window ends if bit 20 is clear, bit 31 is clear or N = 0.
- R7: At the end of a window, the counts of that window, including its last cycle, become the values read at indices 9..14, and the live counters restart from zero. Control bit 30 is set and `irq` equals bit 30. While bit 20 is set, reads return the frozen values. While bit 20 is clear, reads return the live counts.
- R8: Writing control with bit 30 set clears the flag. Writing bit 30 as 0 leaves the flag unchanged. A window end in the same cycle wins over the clear.
- R9: A write of any value to a counter index clears that counter. The major masks keep all 32 written bits. The subport masks keep the low 16 bits and read zero above them. A channel whose two masks are both zero counts nothing.
- R10: Counters saturate at all-ones of CNT_W bits (0xFFFFFFFF by default) and never wrap.
- R11: The registers sit at byte address index×4. Index 0 is control, 1..8 are the filters, 9..14 are the counters and 15 is the timer. An access with address bits 1:0 not zero is ignored. Reads are combinational while `bus_sel` is high, and a write takes effect on the edge where `bus_sel`, `bus_en` and `bus_wr` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register bus select |
| bus_en | input | 1 | Register bus access phase |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not selected |
| req_stb | input | 1 | One request this cycle |
| gnt_stb | input | 1 | One grant this cycle |
| gnt_port | input | PORT_W | Port number of the grant |
| irq | output | 1 | Window-end interrupt (control bit 30) |

## Verification
The bench measures the gap from the enabling write to the first interrupt to the exact cycle. A window counter that is off by one would shift that edge. It then puts traffic into a window and reads the counters both during and after the window. A design that showed live counts in timer mode, or did not clear the live counters at the window end, would report nonzero values where zero is expected. The bench also checks the clear-by-writing-one flag against a write of zero, pushes a narrow counter past its ceiling to expose wrap-around, and sends subport traffic to a channel whose major mask lacks bit 23. It also runs timer mode with a zero window length, where a careless compare would fire every cycle.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;
   localparam int REG_W       = 32;
   localparam int IDX_CTRL    = 0;
   localparam int IDX_FILT0   = 1;
   localparam int IDX_CNT0    = 9;
   localparam int IDX_TIMER   = 15;
   localparam int BIT_ENABLE  = 31;
   localparam int BIT_FLAG    = 30;
   localparam int BIT_TMODE   = 20;
   localparam int BIT_DEVICE  = 23;
   localparam int MAJOR_PORTS = 32;
   localparam int MAX_CH      = 4;
endpackage

// File: rtl/bwmon_port_match.sv
module bwmon_port_match
   import bwmon_pkg::*;
#(
   parameter int PORT_W = 6,
   parameter int SUB_W  = 16
) (
   input  logic [PORT_W-1:0] port,
   input  logic [REG_W-1:0]  major_mask,
   input  logic [SUB_W-1:0]  sub_mask,
   output logic              hit
);
   logic              is_major;
   logic [PORT_W-1:0] sub_idx;
   logic              major_hit;
   logic              sub_hit;

   assign is_major = (port < PORT_W'(MAJOR_PORTS));
   assign sub_idx  = port - PORT_W'(MAJOR_PORTS);

   always_comb begin
      major_hit = 1'b0;
      for (int i = 0; i < MAJOR_PORTS; i++)
         if (port == PORT_W'(i)) major_hit = major_mask[i];
   end

   always_comb begin
      sub_hit = 1'b0;
      for (int i = 0; i < SUB_W; i++)
         if (sub_idx == PORT_W'(i)) sub_hit = sub_mask[i];
   end

   assign hit = is_major ? major_hit : (major_mask[BIT_DEVICE] & sub_hit);
endmodule

// File: rtl/bwmon_sat_cnt.sv
module bwmon_sat_cnt #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   input  logic         win_end,
   input  logic         show_frozen,
   output logic [W-1:0] live,
   output logic [W-1:0] value
);
   logic [W-1:0] frozen;
   logic [W-1:0] nxt;

   assign nxt = (live == {W{1'b1}}) ? live : live + W'(inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live   <= '0;
         frozen <= '0;
      end else if (clr) begin
         live   <= '0;
         frozen <= '0;
      end else if (win_end) begin
         frozen <= nxt;
         live   <= '0;
      end else begin
         live   <= nxt;
      end
   end

   assign value = show_frozen ? frozen : live;
endmodule

// File: rtl/bwmon_window.sv
module bwmon_window #(
   parameter int TMR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [TMR_W-1:0] limit,
   output logic             win_end
);
   logic [TMR_W-1:0] cyc;

   assign win_end = run && (limit != '0) && (cyc >= limit - TMR_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cyc <= '0;
      else if (!run)    cyc <= '0;
      else if (win_end) cyc <= '0;
      else              cyc <= cyc + TMR_W'(1);
   end
endmodule

// File: rtl/bwmon_regs.sv
module bwmon_regs
   import bwmon_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int SUB_W  = 16,
   parameter int TMR_W  = 32,
   parameter int ADDR_W = 6,
   parameter int NCNT   = NUM_CH + 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_sel,
   input  logic                         bus_en,
   input  logic                         bus_wr,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [REG_W-1:0]             bus_wdata,
   output logic [REG_W-1:0]             bus_rdata,
   input  logic                         win_end,
   input  logic [NCNT-1:0][REG_W-1:0]   cnt_rd,
   output logic                         mon_en,
   output logic                         tmode,
   output logic [NUM_CH-1:0]            chen,
   output logic                         flag,
   output logic [TMR_W-1:0]             timer,
   output logic [NUM_CH-1:0][REG_W-1:0] major_mask,
   output logic [NUM_CH-1:0][SUB_W-1:0] sub_mask,
   output logic [NCNT-1:0]              cnt_clr
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] idx;
   logic             aligned;
   logic             wr_stb;
   logic             wr_ctrl;
   logic [REG_W-1:0] rd;

   assign idx     = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign wr_stb  = bus_sel & bus_en & bus_wr & aligned;
   assign wr_ctrl = wr_stb && (idx == IDX_W'(IDX_CTRL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mon_en <= 1'b0;
         tmode  <= 1'b0;
         chen   <= '0;
         flag   <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            mon_en <= bus_wdata[BIT_ENABLE];
            tmode  <= bus_wdata[BIT_TMODE];
            chen   <= bus_wdata[NUM_CH-1:0];
         end
         if (win_end)                         flag <= 1'b1;
         else if (wr_ctrl && bus_wdata[BIT_FLAG]) flag <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timer      <= '0;
         major_mask <= '0;
         sub_mask   <= '0;
      end else if (wr_stb) begin
         if (idx == IDX_W'(IDX_TIMER)) timer <= bus_wdata[TMR_W-1:0];
         for (int c = 0; c < NUM_CH; c++) begin
            if (idx == IDX_W'(IDX_FILT0 + 2*c))     major_mask[c] <= bus_wdata;
            if (idx == IDX_W'(IDX_FILT0 + 2*c + 1)) sub_mask[c]   <= bus_wdata[SUB_W-1:0];
         end
      end
   end

   genvar k;
   generate
      for (k = 0; k < NCNT; k++) begin : g_clr
         assign cnt_clr[k] = wr_stb && (idx == IDX_W'(IDX_CNT0 + k));
      end
   endgenerate

   always_comb begin
      rd = '0;
      if (idx == IDX_W'(IDX_CTRL)) begin
         rd[BIT_ENABLE]   = mon_en;
         rd[BIT_FLAG]     = flag;
         rd[BIT_TMODE]    = tmode;
         rd[NUM_CH-1:0]   = chen;
      end
      for (int c = 0; c < NUM_CH; c++) begin
         if (idx == IDX_W'(IDX_FILT0 + 2*c))     rd = major_mask[c];
         if (idx == IDX_W'(IDX_FILT0 + 2*c + 1)) rd[SUB_W-1:0] = sub_mask[c];
      end
      for (int j = 0; j < NCNT; j++)
         if (idx == IDX_W'(IDX_CNT0 + j)) rd = cnt_rd[j];
      if (idx == IDX_W'(IDX_TIMER)) rd[TMR_W-1:0] = timer;
   end

   assign bus_rdata = (bus_sel && aligned) ? rd : '0;
endmodule

// File: rtl/bwmon_top.sv
module bwmon_top
   import bwmon_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int PORT_W = 6,
   parameter int SUB_W  = 16,
   parameter int CNT_W  = 32,
   parameter int TMR_W  = 32,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              req_stb,
   input  logic              gnt_stb,
   input  logic [PORT_W-1:0] gnt_port,
   output logic              irq
);
   localparam int NCNT = NUM_CH + 2;

   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
         $error("NUM_CH must be 1..4");
      end
      if (CNT_W < 1 || CNT_W > REG_W) begin : g_bad_cnt
         $error("CNT_W must be 1..32");
      end
      if (TMR_W < 1 || TMR_W > REG_W) begin : g_bad_tmr
         $error("TMR_W must be 1..32");
      end
      if (SUB_W < 1 || SUB_W > REG_W) begin : g_bad_sub
         $error("SUB_W must be 1..32");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W must be at least 6");
      end
      if (PORT_W < 6) begin : g_bad_port
         $error("PORT_W must be at least 6");
      end
   endgenerate

   logic                         mon_en;
   logic                         tmode;
   logic [NUM_CH-1:0]            chen;
   logic                         flag;
   logic [TMR_W-1:0]             timer;
   logic [NUM_CH-1:0][REG_W-1:0] major_mask;
   logic [NUM_CH-1:0][SUB_W-1:0] sub_mask;
   logic [NCNT-1:0]              cnt_clr;
   logic [NCNT-1:0]              cnt_inc;
   logic [NCNT-1:0][REG_W-1:0]   cnt_rd;
   logic [NCNT-1:0][CNT_W-1:0]   cnt_live;
   logic [NUM_CH-1:0]            ch_hit;
   logic                         run;
   logic                         win_end;

   bwmon_regs #(
      .NUM_CH (NUM_CH),
      .SUB_W  (SUB_W),
      .TMR_W  (TMR_W),
      .ADDR_W (ADDR_W),
      .NCNT   (NCNT)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_en     (bus_en),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .win_end    (win_end),
      .cnt_rd     (cnt_rd),
      .mon_en     (mon_en),
      .tmode      (tmode),
      .chen       (chen),
      .flag       (flag),
      .timer      (timer),
      .major_mask (major_mask),
      .sub_mask   (sub_mask),
      .cnt_clr    (cnt_clr)
   );

   assign run = mon_en & tmode;

   bwmon_window #(.TMR_W(TMR_W)) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .limit   (timer),
      .win_end (win_end)
   );

   assign cnt_inc[0] = mon_en & req_stb;
   assign cnt_inc[1] = mon_en & gnt_stb;

   genvar c, k;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_ch
         bwmon_port_match #(.PORT_W(PORT_W), .SUB_W(SUB_W)) u_match (
            .port       (gnt_port),
            .major_mask (major_mask[c]),
            .sub_mask   (sub_mask[c]),
            .hit        (ch_hit[c])
         );
         assign cnt_inc[2+c] = mon_en & chen[c] & gnt_stb & ch_hit[c];
      end

      for (k = 0; k < NCNT; k++) begin : g_cnt
         logic [CNT_W-1:0] val;
         bwmon_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk         (clk),
            .rst_n       (rst_n),
            .inc         (cnt_inc[k]),
            .clr         (cnt_clr[k]),
            .win_end     (win_end),
            .show_frozen (tmode),
            .live        (cnt_live[k]),
            .value       (val)
         );
         always_comb begin
            cnt_rd[k]          = '0;
            cnt_rd[k][CNT_W-1:0] = val;
         end
      end
   endgenerate

   assign irq = flag;
endmodule

// File: rtl/bwmon_chk.sv
module bwmon_chk #(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic              win_end,
   input logic              run,
   input logic              mon_en,
   input logic [CNT_W-1:0]  live_req,
   input logic              req_clr,
   input logic              bus_sel,
   input logic              bus_en,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              wdata_flag
);
   logic clr_write;
   assign clr_write = bus_sel && bus_en && bus_wr && (bus_addr == '0) && wdata_flag;

   AST_IRQ_ON_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> irq); // R7

   AST_LIVE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && !req_clr) |=> (live_req == '0)); // R7

   AST_NO_WINDOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !win_end); // R6

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (live_req == {CNT_W{1'b1}} && !win_end && !req_clr) |=> (live_req == {CNT_W{1'b1}})); // R10

   AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!mon_en && !req_clr) |=> $stable(live_req)); // R3

   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_write && !win_end) |=> !irq); // R8
endmodule

bind bwmon_top bwmon_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq        (irq),
   .win_end    (win_end),
   .run        (run),
   .mon_en     (mon_en),
   .live_req   (cnt_live[0]),
   .req_clr    (cnt_clr[0]),
   .bus_sel    (bus_sel),
   .bus_en     (bus_en),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .wdata_flag (bus_wdata[30])
);

// File: tb/bwmon_top_tb.sv
`timescale 1ns/1ps
module bwmon_top_tb;
   localparam int CNT_W = 8;
   localparam int TMR_N = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_en = 1'b0, bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        req_stb = 1'b0, gnt_stb = 1'b0;
   logic [5:0]  gnt_port = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bwmon_top #(.CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .req_stb(req_stb), .gnt_stb(gnt_stb), .gnt_port(gnt_port), .irq(irq)
   );

   task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, got, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_en = 1'b0;
      bus_addr = 6'(idx * 4); bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input int idx, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'(idx * 4);
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic pulse(input bit rq, input bit gn, input logic [5:0] port, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_stb = rq; gnt_stb = gn; gnt_port = port;
      end
      @(negedge clk);
      req_stb = 1'b0; gnt_stb = 1'b0;
   endtask

   task automatic wait_irq(output int cyc);
      cyc = 0;
      while (irq !== 1'b1 && cyc < 200) begin
         @(posedge clk); #1; cyc++;
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1", "irq after reset", {31'b0, irq}, 32'h0);
      for (int i = 0; i < 16; i++) begin
         rd(i, v);
         check("R1", $sformatf("reg %0d after reset", i), v, 32'h0);
      end
   endtask

   task automatic t_regmap();
      logic [31:0] v;
      wr(1, 32'hA5A5_0001); rd(1, v); check("R9", "major mask 0 keeps 32 bits", v, 32'hA5A5_0001);
      wr(2, 32'hFFFF_FFFF); rd(2, v); check("R9", "subport mask 16 bits", v, 32'h0000_FFFF);
      wr(15, 32'h1234_5678); rd(15, v); check("R11", "timer at index 15", v, 32'h1234_5678);
      @(negedge clk);
      bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b1; bus_addr = 6'd61; bus_wdata = 32'h0;
      @(negedge clk); bus_en = 1'b1;
      @(negedge clk); bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
      rd(15, v); check("R11", "misaligned write ignored", v, 32'h1234_5678);
      wr(1, 0); wr(2, 0); wr(15, 0);
   endtask

   task automatic t_all_counts();
      logic [31:0] v;
      wr(0, 32'h8000_0000);
      pulse(1, 0, 6'd0, 5);
      pulse(0, 1, 6'd9, 3);
      rd(9, v);  check("R2", "all-request count", v, 5);
      rd(10, v); check("R2", "all-grant count", v, 3);
      rd(11, v); check("R2", "channel with no enable stays 0", v, 0);
      wr(0, 0);
      pulse(1, 1, 6'd9, 4);
      rd(9, v);  check("R3", "requests ignored while disabled", v, 5);
      rd(10, v); check("R3", "grants ignored while disabled", v, 3);
      wr(9, 32'hDEAD_BEEF);
      rd(9, v);  check("R9", "counter write clears", v, 0);
      rd(10, v); check("R9", "other counter untouched", v, 3);
      wr(10, 0);
   endtask

   task automatic t_major();
      logic [31:0] v;
      wr(1, 32'h0000_0020); wr(3, 32'h0000_0080); wr(7, 32'h0000_0020);
      wr(0, 32'h8000_0007);
      pulse(0, 1, 6'd5, 2);
      pulse(0, 1, 6'd7, 1);
      pulse(0, 1, 6'd9, 1);
      rd(11, v); check("R4", "ch0 port 5", v, 2);
      rd(12, v); check("R4", "ch1 port 7", v, 1);
      rd(13, v); check("R4", "ch2 empty mask", v, 0);
      rd(14, v); check("R4", "ch3 disabled channel", v, 0);
      rd(10, v); check("R2", "all grants unfiltered", v, 4);
   endtask

   task automatic t_sub();
      logic [31:0] v;
      for (int i = 11; i < 15; i++) wr(i, 0);
      wr(5, 32'h0080_0000); wr(6, 32'h0000_0008);
      pulse(0, 1, 6'd35, 2);
      pulse(0, 1, 6'd36, 1);
      pulse(0, 1, 6'd5, 1);
      rd(13, v); check("R5", "ch2 subport 3", v, 2);
      rd(11, v); check("R5", "ch0 without device bit ignores subports", v, 1);
      wr(5, 0); wr(6, 0); wr(13, 0);
      pulse(0, 1, 6'd35, 2);
      rd(13, v); check("R9", "zeroed filters count nothing", v, 0);
   endtask

   task automatic t_saturate();
      logic [31:0] v;
      wr(9, 0);
      wr(0, 32'h8000_0000);
      pulse(1, 0, 6'd0, 300);
      rd(9, v); check("R10", "saturated request counter", v, 32'h0000_00FF);
      wr(0, 0);
   endtask

   task automatic t_window();
      logic [31:0] v;
      int cyc;
      for (int i = 9; i < 15; i++) wr(i, 0);
      wr(1, 32'h0000_0020);
      wr(15, TMR_N);
      wr(0, 32'h8010_0001);
      wait_irq(cyc);
      check("R6", "cycles to first window end", cyc, TMR_N);
      pulse(1, 1, 6'd5, 3);
      rd(10, v); check("R7", "timer mode shows frozen value", v, 0);
      wr(0, 32'h8010_0001);
      check("R8", "writing flag bit 0 keeps irq", {31'b0, irq}, 1);
      wr(0, 32'hC010_0001);
      check("R8", "writing flag bit 1 clears irq", {31'b0, irq}, 0);
      rd(0, v); check("R8", "control readback after clear", v, 32'h8010_0001);
      wait_irq(cyc);
      check("R7", "irq raised at second window", {31'b0, irq}, 1);
      rd(9, v);  check("R7", "frozen request count", v, 3);
      rd(10, v); check("R7", "frozen grant count", v, 3);
      rd(11, v); check("R7", "frozen ch0 count", v, 3);
      rd(0, v);  check("R7", "flag bit 30 set", v, 32'hC010_0001);
      wr(0, 32'hC010_0001);
      wait_irq(cyc);
      rd(10, v); check("R7", "next window restarted from zero", v, 0);
      wr(0, 32'h4000_0000);
      repeat (60) @(posedge clk);
      #1 check("R6", "no window with timer mode off", {31'b0, irq}, 0);
      wr(15, 0);
      wr(0, 32'h8010_0000);
      repeat (60) @(posedge clk);
      #1 check("R6", "no window with zero length", {31'b0, irq}, 0);
      wr(0, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_all_counts();
      t_major();
      t_sub();
      t_saturate();
      t_window();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule